// File: doc/BRIEF.md
# Text-Mode Register Init Sequencer

This block puts a display controller's register file into a known text mode without software involvement. After a one-cycle start pulse it reads a small built-in table of indexed-register entries and turns each entry into two byte writes on a simple I/O write bus. The first write puts the register index on the entry's port. The second puts the register value on the next port up. A port field of all ones ends the table.

After the table the block sends a fixed tail. It writes the miscellaneous output byte, then the colour mask, then 21 attribute-controller write pairs. Only the last attribute pair sets the video-enable flag, so the screen stays blanked until every other register holds its final value. When the last write has gone out, the block pulses `done` for one cycle and returns to idle.

The controller has eight states. `ST_IDLE` waits for start. `ST_TBL_IDX` issues an entry's index write, or detects the end marker. `ST_TBL_VAL` issues the entry's value write. `ST_MISC` and `ST_MASK` issue the two fixed tail writes. `ST_ATR_IDX` and `ST_ATR_VAL` issue each attribute address and data byte. `ST_DONE` raises the done pulse.

The transitions are as follows:
- Start moves `ST_IDLE` to `ST_TBL_IDX`.
- `ST_TBL_IDX` goes to `ST_TBL_VAL` for a real entry, and to `ST_MISC` on the marker.
- `ST_TBL_VAL` goes back to `ST_TBL_IDX`.
- `ST_MISC` goes to `ST_MASK`, and `ST_MASK` goes to `ST_ATR_IDX`.
- `ST_ATR_IDX` goes to `ST_ATR_VAL`.
- `ST_ATR_VAL` goes back to `ST_ATR_IDX`, or to `ST_DONE` after slot 20.
- `ST_DONE` returns to `ST_IDLE`.

Top module: `txtinit_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) returns the block to idle with no write strobe and `done` low. This holds even in the middle of a sequence. The next start replays the table from entry zero.
- R2: A start pulse sampled while idle begins a sequence. The first write strobe appears in the cycle right after the edge that sampled start.
- R3: Every write lasts one cycle with `io_wr` high for that cycle only, and at most one write occurs per cycle. For each table entry, the index byte goes to the entry's port in one cycle and the value byte goes to port+1 in the very next cycle.
- R4: The table holds 37 entries, issued in this order:
  - port 0x3C4, indices 1 to 4, values 00 03 00 02;
  - port 0x3D4, indices 0x00 to 0x17, values 5F 4F 50 82 55 81 BF 1F 00 4F 0D 0E 00 00 00 00 9C 8E 8F 28 1F 96 B9 A3;
  - port 0x3CE, indices 0 to 8, values 00 00 00 00 00 10 0E 00 FF.
- R5: The entry whose port equals 0xFFFF ends the table and is never issued as a write. It costs exactly one cycle without a strobe between the last table write and the first tail write.
- R6: After the table, the block writes 0x67 to port 0x3C2 and then 0xFF to port 0x3C6, in consecutive cycles.
- R7: The block then issues 21 attribute pairs on port 0x3C0, for attribute indices 0x00 to 0x14 in order. Each pair is an address byte followed by a data byte. The data bytes are as follows:
  - indices 0x00 to 0x05 carry the index itself;
  - index 0x06 carries 0x14 and index 0x07 carries 0x07;
  - indices 0x08 to 0x0F carry 0x30 plus the index;
  - indices 0x10 to 0x14 carry 0C 00 0F 08 00.
- R8: The attribute address byte is the index in bits 4:0. Bit 5, the video-enable flag, is set only in the address byte for index 0x14 and is clear in every earlier one.
- R9: `done` is high for exactly one cycle, the cycle after the final attribute data write, with no strobe in that cycle. The block is idle afterwards. One sequence issues 118 writes in total.
- R10: A start pulse that arrives while a sequence runs, or in the same cycle as `done`, is ignored. It produces no extra write and no second `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to run the sequence |
| io_wr | output | 1 | Write strobe, one cycle per byte |
| io_addr | output | 16 | Port address of the current write |
| io_data | output | 8 | Byte written |
| done | output | 1 | One-cycle pulse after the last write |

## Verification
A new start request can coincide with the running sequence, and most sharply with the cycle in which `done` is raised. The bench provokes both cases. It sprinkles random start pulses over every cycle of some runs, and it drives start exactly in the `done` cycle. It then judges the result at the bus. The write stream must still match the expected 118-write list, and the cycles after `done` must show no strobe and no second pulse. A reset dropped at a random point mid-sequence is followed by a fresh run, which must start again from table entry zero.

// File: rtl/txtinit_pkg.sv
package txtinit_pkg;

    localparam logic [15:0] END_MARK   = 16'hFFFF;
    localparam logic [15:0] MISC_PORT  = 16'h03C2;
    localparam logic [7:0]  MISC_VAL   = 8'h67;
    localparam logic [15:0] MASK_PORT  = 16'h03C6;
    localparam logic [7:0]  MASK_VAL   = 8'hFF;
    localparam logic [15:0] ATTR_PORT  = 16'h03C0;
    localparam logic [7:0]  VIDEO_FLAG = 8'h20;

    typedef struct packed {
        logic [15:0] port;
        logic [7:0]  idx;
        logic [7:0]  val;
    } reg_ent_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TBL_IDX,
        ST_TBL_VAL,
        ST_MISC,
        ST_MASK,
        ST_ATR_IDX,
        ST_ATR_VAL,
        ST_DONE
    } seq_st_t;

endpackage

// File: rtl/txtinit_rom.sv
module txtinit_rom
    import txtinit_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic [AW-1:0] addr,
    output reg_ent_t      ent
);
    localparam int SEQ_BASE = 0;
    localparam int CRT_BASE = 4;
    localparam int GFX_BASE = 28;
    localparam int TBL_LEN  = 37;

    logic [7:0] val;

    // Register values, one per table slot; slots past the end read zero.
    always_comb begin
        case (int'(addr))
            0:  val = 8'h00;  1:  val = 8'h03;  2:  val = 8'h00;  3:  val = 8'h02;
            4:  val = 8'h5F;  5:  val = 8'h4F;  6:  val = 8'h50;  7:  val = 8'h82;
            8:  val = 8'h55;  9:  val = 8'h81;  10: val = 8'hBF;  11: val = 8'h1F;
            12: val = 8'h00;  13: val = 8'h4F;  14: val = 8'h0D;  15: val = 8'h0E;
            16: val = 8'h00;  17: val = 8'h00;  18: val = 8'h00;  19: val = 8'h00;
            20: val = 8'h9C;  21: val = 8'h8E;  22: val = 8'h8F;  23: val = 8'h28;
            24: val = 8'h1F;  25: val = 8'h96;  26: val = 8'hB9;  27: val = 8'hA3;
            33: val = 8'h10;  34: val = 8'h0E;  36: val = 8'hFF;
            default: val = 8'h00;
        endcase
    end

    // Port and index follow from the slot's group.
    always_comb begin
        int a;
        a = int'(addr);
        if (a < CRT_BASE) begin
            ent = '{port: 16'h03C4, idx: 8'(a - SEQ_BASE + 1), val: val};
        end else if (a < GFX_BASE) begin
            ent = '{port: 16'h03D4, idx: 8'(a - CRT_BASE), val: val};
        end else if (a < TBL_LEN) begin
            ent = '{port: 16'h03CE, idx: 8'(a - GFX_BASE), val: val};
        end else begin
            ent = '{port: END_MARK, idx: 8'h00, val: 8'h00};
        end
    end
endmodule

// File: rtl/txtinit_attr.sv
module txtinit_attr
    import txtinit_pkg::*;
#(
    parameter int CW        = 5,
    parameter int LAST_SLOT = 20
) (
    input  logic [CW-1:0] slot,
    output logic [7:0]    sel,
    output logic [7:0]    val
);
    always_comb begin
        sel = 8'(slot) & 8'h1F;
        if (int'(slot) == LAST_SLOT) begin
            sel = sel | VIDEO_FLAG;
        end
    end

    always_comb begin
        int s;
        s = int'(slot);
        if (s < 6) begin
            val = 8'(s);
        end else if (s == 6) begin
            val = 8'h14;
        end else if (s == 7) begin
            val = 8'h07;
        end else if (s < 16) begin
            val = 8'(8'h30 + s);
        end else begin
            case (s)
                16:      val = 8'h0C;
                18:      val = 8'h0F;
                19:      val = 8'h08;
                default: val = 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/txtinit_seq.sv
module txtinit_seq
    import txtinit_pkg::*;
#(
    parameter int TBL_AW   = 6,
    parameter int ATTR_CNT = 21
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    output logic        io_wr,
    output logic [15:0] io_addr,
    output logic [7:0]  io_data,
    output logic        done
);
    localparam int ACW = $clog2(ATTR_CNT);
    localparam logic [ACW-1:0] ATTR_LAST = ACW'(ATTR_CNT - 1);

    seq_st_t         state, nxt;
    logic [TBL_AW-1:0] ptr;
    logic [ACW-1:0]    acnt;
    reg_ent_t          ent;
    logic              at_end;
    logic [7:0]        a_sel, a_val;

    txtinit_rom #(.AW(TBL_AW)) u_rom (
        .addr (ptr),
        .ent  (ent)
    );

    txtinit_attr #(.CW(ACW), .LAST_SLOT(ATTR_CNT - 1)) u_attr (
        .slot (acnt),
        .sel  (a_sel),
        .val  (a_val)
    );

    assign at_end = (ent.port == END_MARK);

    // Next-state decode
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (start) nxt = ST_TBL_IDX;
            ST_TBL_IDX: nxt = at_end ? ST_MISC : ST_TBL_VAL;
            ST_TBL_VAL: nxt = ST_TBL_IDX;
            ST_MISC:    nxt = ST_MASK;
            ST_MASK:    nxt = ST_ATR_IDX;
            ST_ATR_IDX: nxt = ST_ATR_VAL;
            ST_ATR_VAL: nxt = (acnt == ATTR_LAST) ? ST_DONE : ST_ATR_IDX;
            ST_DONE:    nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // State register with table pointer and attribute slot counter
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            ptr   <= '0;
            acnt  <= '0;
        end else begin
            state <= nxt;
            unique case (state)
                ST_IDLE:    begin ptr <= '0; acnt <= '0; end
                ST_TBL_VAL: ptr <= ptr + 1'b1;
                ST_MASK:    acnt <= '0;
                ST_ATR_VAL: if (acnt != ATTR_LAST) acnt <= acnt + 1'b1;
                ST_DONE:    begin ptr <= '0; acnt <= '0; end
                default:    ;
            endcase
        end
    end

    // Bus outputs
    always_comb begin
        io_wr   = 1'b0;
        io_addr = 16'h0000;
        io_data = 8'h00;
        done    = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_TBL_IDX: begin
                if (!at_end) begin
                    io_wr   = 1'b1;
                    io_addr = ent.port;
                    io_data = ent.idx;
                end
            end
            ST_TBL_VAL: begin
                io_wr   = 1'b1;
                io_addr = ent.port + 16'h0001;
                io_data = ent.val;
            end
            ST_MISC: begin
                io_wr   = 1'b1;
                io_addr = MISC_PORT;
                io_data = MISC_VAL;
            end
            ST_MASK: begin
                io_wr   = 1'b1;
                io_addr = MASK_PORT;
                io_data = MASK_VAL;
            end
            ST_ATR_IDX: begin
                io_wr   = 1'b1;
                io_addr = ATTR_PORT;
                io_data = a_sel;
            end
            ST_ATR_VAL: begin
                io_wr   = 1'b1;
                io_addr = ATTR_PORT;
                io_data = a_val;
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/txtinit_chk.sv
module txtinit_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        io_wr,
    input logic [15:0] io_addr,
    input logic [7:0]  io_data,
    input logic        done
);
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !io_wr);

    // R5
    no_marker_write_chk: assert property (@(posedge clk) disable iff (rst)
        io_wr |-> (io_addr != 16'hFFFF));

    // R6
    misc_value_chk: assert property (@(posedge clk) disable iff (rst)
        (io_wr && io_addr == 16'h03C2) |-> (io_data == 8'h67));

    // R3
    pair_order_chk: assert property (@(posedge clk) disable iff (rst)
        (io_wr && (io_addr == 16'h03C5 || io_addr == 16'h03D5 || io_addr == 16'h03CF))
        |-> ($past(io_wr) && $past(io_addr) == io_addr - 16'h0001));

    // R9
    done_after_attr_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(io_wr) && $past(io_addr) == 16'h03C0));
endmodule

bind txtinit_seq txtinit_chk u_chk (.*);

// File: tb/txtinit_seq_bench.sv
module txtinit_seq_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        io_wr;
    logic [15:0] io_addr;
    logic [7:0]  io_data;
    logic        done;

    int checks = 0;
    int errors = 0;

    localparam int NTBL   = 37;
    localparam int NWRITE = 118;
    localparam logic [7:0] TV [NTBL] = '{
        8'h00, 8'h03, 8'h00, 8'h02,
        8'h5F, 8'h4F, 8'h50, 8'h82, 8'h55, 8'h81, 8'hBF, 8'h1F,
        8'h00, 8'h4F, 8'h0D, 8'h0E, 8'h00, 8'h00, 8'h00, 8'h00,
        8'h9C, 8'h8E, 8'h8F, 8'h28, 8'h1F, 8'h96, 8'hB9, 8'hA3,
        8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h10, 8'h0E, 8'h00, 8'hFF};
    localparam logic [7:0] AV [21] = '{
        8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h14, 8'h07,
        8'h38, 8'h39, 8'h3A, 8'h3B, 8'h3C, 8'h3D, 8'h3E, 8'h3F,
        8'h0C, 8'h00, 8'h0F, 8'h08, 8'h00};

    always #5 clk = ~clk;

    txtinit_seq u_txtinit_seq (
        .clk(clk), .rst(rst), .start(start),
        .io_wr(io_wr), .io_addr(io_addr), .io_data(io_data), .done(done)
    );

    function automatic logic [23:0] exp_write(input int n);
        logic [15:0] p;
        logic [7:0]  ix;
        int e, a;
        if (n < 2 * NTBL) begin
            e = n / 2;
            if (e < 4) begin p = 16'h03C4; ix = 8'(e + 1); end
            else if (e < 28) begin p = 16'h03D4; ix = 8'(e - 4); end
            else begin p = 16'h03CE; ix = 8'(e - 28); end
            return (n % 2 == 0) ? {p, ix} : {p + 16'h1, TV[e]};
        end
        if (n == 2 * NTBL)     return {16'h03C2, 8'h67};
        if (n == 2 * NTBL + 1) return {16'h03C6, 8'hFF};
        a = (n - 2 * NTBL - 2) / 2;
        if ((n - 2 * NTBL - 2) % 2 == 0)
            return {16'h03C0, 8'(a) | ((a == 20) ? 8'h20 : 8'h00)};
        return {16'h03C0, AV[a]};
    endfunction

    function automatic string tag_of(input int n);
        if (n < 2 * NTBL) return (n % 2) ? "R3/R4 value" : "R4 index";
        if (n < 2 * NTBL + 2) return "R6";
        if ((n - 2 * NTBL) % 2 == 0) return "R8 attr addr";
        return "R7 attr data";
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Runs one sequence. noisy: random start pulses while running and at done.
    // rst_at >= 0 drops a reset at that cycle of the run.
    task automatic run_seq(input bit noisy, input int rst_at);
        int n = 0;
        int gaps = 0;
        bit seen_done = 1'b0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        // R2: first write right after the start edge
        check(io_wr == 1'b1, "R2 first strobe", int'(io_wr), 1);
        for (int cyc = 0; cyc < 400; cyc++) begin
            if (cyc == rst_at) begin
                rst = 1'b1;
                @(negedge clk) rst = 1'b0;
                // R1: reset mid-run leaves idle
                check(io_wr == 1'b0 && done == 1'b0, "R1 reset idle",
                      {io_wr, done}, 0);
                return;
            end
            if (done) begin
                seen_done = 1'b1;
                // R9: total writes and quiet done cycle
                check(n == NWRITE, "R9 write count", n, NWRITE);
                check(io_wr == 1'b0, "R9 no write with done", int'(io_wr), 0);
                // R5: exactly one strobe-free cycle in the run
                check(gaps == 1, "R5 marker gap", gaps, 1);
                if (noisy) start = 1'b1;  // R10 start coinciding with done
                break;
            end
            if (io_wr) begin
                logic [23:0] w;
                w = exp_write(n);
                check({io_addr, io_data} == w, tag_of(n),
                      int'({io_addr, io_data}), int'(w));
                n++;
            end else begin
                gaps++;
            end
            start = (noisy && ($urandom % 4 == 0)) ? 1'b1 : 1'b0;
            @(negedge clk);
        end
        check(seen_done, "R9 done seen", int'(seen_done), 1);
        @(negedge clk) start = 1'b0;
        for (int k = 0; k < 4; k++) begin
            // R10 / R9: nothing follows the single done pulse
            check(io_wr == 1'b0 && done == 1'b0, "R10 ignored start",
                  {io_wr, done}, 0);
            @(negedge clk);
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check(io_wr == 1'b0 && done == 1'b0, "R1 after reset", {io_wr, done}, 0);
        repeat (2) @(negedge clk);
        check(io_wr == 1'b0, "R1 idle without start", int'(io_wr), 0);

        run_seq(1'b0, -1);
        run_seq(1'b1, -1);
        run_seq(1'b0, 1 + int'($urandom % 100));
        run_seq(1'b0, -1);  // R1: replays from entry zero after reset
        for (int r = 0; r < 3; r++) begin
            repeat (int'($urandom % 5)) @(negedge clk);
            run_seq(1'b1, -1);
        end
        run_seq(1'b0, 73);  // reset right at the marker step
        run_seq(1'b1, -1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule